// File: doc/BRIEF.md
# Table-Loaded Note Duration Counter

This block times how long a note on one sound channel stays audible. Writing a 5-bit length index looks up an 8-bit starting count in a fixed 32-entry duration table and loads it. After that, the count drops by one on each 120 Hz frame tick until it reaches zero. A halt input freezes the countdown. A channel enable clears the count and locks it at zero.

The block drives the count and a nonzero flag. The rest of the channel uses that flag as a mute gate: while it is low the channel is silent. Waveform generation is not part of this block. The frame tick is a one-cycle enable in the system clock domain, not a separate clock.

Top module: `note_len_counter`

## Requirements
- R1: After reset, `count` is 0 and `active` is 0.
- R2: A load with `lenIdx[0]` = 1 selects the regular half of the table. With k = `lenIdx[4:1]`, the count becomes 2*k for k from 1 to 15 and 0xFE for k = 0. The new value appears after the clock edge at which `loadStb` is sampled.
- R3: A load with `lenIdx[0]` = 0 selects the irregular half of the table. For k = `lenIdx[4:1]` from 0 to 15, the count becomes, in that order: 0x0A, 0x14, 0x28, 0x50, 0xA0, 0x3C, 0x0E, 0x1A, 0x0C, 0x18, 0x30, 0x60, 0xC0, 0x48, 0x10, 0x20.
- R4: When enabled, not loading and not halted, a clock edge with `frameTick` high lowers a nonzero count by exactly one.
- R5: A clock edge with `frameTick` low and no load leaves the count unchanged.
- R6: While `haltCount` is high, a tick without a load leaves the count unchanged.
- R7: A count of zero stays at zero on a tick. It never wraps to 0xFF.
- R8: When a load and a tick arrive in the same cycle, the load wins. This holds whether or not halt is set.
- R9: With `chanEn` low, the count goes to 0 on the next edge and any load in that cycle is ignored.
- R10: `active` is high exactly when `count` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle 120 Hz frame enable |
| haltCount | input | 1 | Freezes the countdown while high |
| lenIdx | input | 5 | Duration table index |
| loadStb | input | 1 | Loads the table value for `lenIdx` |
| chanEn | input | 1 | Channel enable; low clears the count |
| count | output | 8 | Current remaining duration |
| active | output | 1 | High while the count is nonzero, used as the mute gate |

## Verification
The hardest situation to reach from the ports is a tick arriving while the count is already at zero. Getting there takes a load followed by as many as 254 unhalted ticks with no new load in between. Random loads would usually cut that run short. The stimulus therefore includes directed runs that load the smallest entries, such as 2 and 0x0A, and tick every cycle past zero. A separate long run from 0xFE drains the largest entry. Random phases with a low load rate then revisit the zero boundary many times under mixed halt and enable settings.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
  localparam int IDX_W = 5;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic clear;
    logic load;
    logic dec;
  } nlc_strobes_t;

  // Duration table: bit 0 picks the half, bits 4:1 pick the entry.
  function automatic logic [CNT_W-1:0] lenLookup(input logic [IDX_W-1:0] idx);
    logic [3:0] entry;
    logic [CNT_W-1:0] val;
    entry = idx[IDX_W-1:1];
    if (idx[0]) begin
      val = (entry == 4'd0) ? CNT_W'(8'hFE) : CNT_W'({entry, 1'b0});
    end else begin
      unique case (entry)
        4'd0:  val = CNT_W'(8'h0A);
        4'd1:  val = CNT_W'(8'h14);
        4'd2:  val = CNT_W'(8'h28);
        4'd3:  val = CNT_W'(8'h50);
        4'd4:  val = CNT_W'(8'hA0);
        4'd5:  val = CNT_W'(8'h3C);
        4'd6:  val = CNT_W'(8'h0E);
        4'd7:  val = CNT_W'(8'h1A);
        4'd8:  val = CNT_W'(8'h0C);
        4'd9:  val = CNT_W'(8'h18);
        4'd10: val = CNT_W'(8'h30);
        4'd11: val = CNT_W'(8'h60);
        4'd12: val = CNT_W'(8'hC0);
        4'd13: val = CNT_W'(8'h48);
        4'd14: val = CNT_W'(8'h10);
        default: val = CNT_W'(8'h20);
      endcase
    end
    return val;
  endfunction
endpackage

// File: rtl/nlc_ctrl.sv
module nlc_ctrl
  import nlc_pkg::*;
(
  input  logic         chanEn,
  input  logic         loadStb,
  input  logic         frameTick,
  input  logic         haltCount,
  input  logic         isZero,
  output nlc_strobes_t strobes
);
  // Priority: disable clears, then load, then decrement.
  always_comb begin
    strobes = '0;
    if (!chanEn) begin
      strobes.clear = 1'b1;
    end else if (loadStb) begin
      strobes.load = 1'b1;
    end else if (frameTick && !haltCount && !isZero) begin
      strobes.dec = 1'b1;
    end
  end
endmodule

// File: rtl/nlc_datapath.sv
module nlc_datapath
  import nlc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  nlc_strobes_t     strobes,
  input  logic [IDX_W-1:0] lenIdx,
  output logic [CNT_W-1:0] count,
  output logic             isZero
);
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] loadVal;

  assign loadVal = lenLookup(lenIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.clear) begin
      countQ <= '0;
    end else if (strobes.load) begin
      countQ <= loadVal;
    end else if (strobes.dec) begin
      countQ <= countQ - CNT_W'(1);
    end
  end

  assign count  = countQ;
  assign isZero = (countQ == '0);
endmodule

// File: rtl/note_len_counter.sv
module note_len_counter
  import nlc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameTick,
  input  logic             haltCount,
  input  logic [IDX_W-1:0] lenIdx,
  input  logic             loadStb,
  input  logic             chanEn,
  output logic [CNT_W-1:0] count,
  output logic             active
);
  nlc_strobes_t strobes;
  logic         isZero;

  nlc_ctrl u_ctrl (
    .chanEn    (chanEn),
    .loadStb   (loadStb),
    .frameTick (frameTick),
    .haltCount (haltCount),
    .isZero    (isZero),
    .strobes   (strobes)
  );

  nlc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lenIdx  (lenIdx),
    .count   (count),
    .isZero  (isZero)
  );

  assign active = !isZero;
endmodule

// File: rtl/nlc_checker.sv
module nlc_checker
  import nlc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameTick,
  input logic             haltCount,
  input logic [IDX_W-1:0] lenIdx,
  input logic             loadStb,
  input logic             chanEn,
  input logic [CNT_W-1:0] count,
  input logic             active
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> count == '0); // R9
  AST_REGULAR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    chanEn && loadStb && lenIdx[0] && lenIdx[4:1] != 4'd0
      |=> count == CNT_W'({$past(lenIdx[4:1]), 1'b0})); // R2
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    chanEn && !loadStb && haltCount |=> $stable(count)); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    chanEn && !loadStb && !frameTick |=> $stable(count)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    chanEn && !loadStb && count == '0 |=> count == '0); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    chanEn && !loadStb && frameTick && !haltCount && count != '0
      |=> count == $past(count) - CNT_W'(1)); // R4
  AST_GATE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    active != (count == '0)); // R10
endmodule

bind note_len_counter nlc_checker u_chk (
  .clk(clk), .rstN(rstN), .frameTick(frameTick), .haltCount(haltCount),
  .lenIdx(lenIdx), .loadStb(loadStb), .chanEn(chanEn),
  .count(count), .active(active)
);

// File: tb/sim_note_len_counter.sv
module sim_note_len_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameTick = 1'b0;
  logic       haltCount = 1'b0;
  logic [4:0] lenIdx = '0;
  logic       loadStb = 1'b0;
  logic       chanEn = 1'b0;
  logic [7:0] count;
  logic       active;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  note_len_counter u0 (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .haltCount(haltCount),
    .lenIdx(lenIdx), .loadStb(loadStb), .chanEn(chanEn),
    .count(count), .active(active)
  );

  function automatic logic [7:0] expLen(input logic [4:0] idx);
    logic [7:0] odd [16] = '{8'h0A, 8'h14, 8'h28, 8'h50, 8'hA0, 8'h3C, 8'h0E, 8'h1A,
                             8'h0C, 8'h18, 8'h30, 8'h60, 8'hC0, 8'h48, 8'h10, 8'h20};
    int k = int'(idx >> 1);
    if (idx[0] == 1'b0) return odd[k];
    if (k == 0) return 8'hFE;
    return 8'(2 * k);
  endfunction

  function automatic logic [7:0] expNext(input logic [7:0] cur, input bit en,
      input bit ld, input bit tk, input bit hl, input logic [4:0] idx);
    if (!en) return 8'h00;
    if (ld) return expLen(idx);
    if (tk && !hl && cur != 0) return cur - 8'd1;
    return cur;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (count !== model) begin
      errors++;
      $display("FAIL %s count=%0h expected=%0h", tag, count, model);
    end
    checks++;
    if (active !== (model != 0)) begin
      errors++;
      $display("FAIL R10 active=%0b expected=%0b", active, model != 0);
    end
  endtask

  // Drive at negedge, advance one edge, sample 1 time unit later.
  task automatic step(input bit en, input bit ld, input bit tk, input bit hl,
                      input logic [4:0] idx, input string tag);
    @(negedge clk);
    chanEn = en; loadStb = ld; frameTick = tk; haltCount = hl; lenIdx = idx;
    model = expNext(model, en, ld, tk, hl, idx);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  function automatic string autoTag(input bit en, input bit ld, input bit tk,
                                    input bit hl, input logic [4:0] idx);
    if (!en) return "R9";
    if (ld && tk) return "R8";
    if (ld) return idx[0] ? "R2" : "R3";
    if (!tk) return "R5";
    if (hl) return "R6";
    if (model == 0) return "R7";
    return "R4";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    model = 8'h00;
    check("R1");
    @(negedge clk);
    rstN = 1'b1;
    // Every table entry, both halves.
    for (int i = 0; i < 32; i++) begin
      step(1, 1, 0, 0, 5'(i), (i % 2 == 1) ? "R2" : "R3");
    end
    // Load smallest entry (2), then run past zero.
    step(1, 1, 0, 0, 5'd3, "R2");
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 5'd0, (i < 2) ? "R4" : "R7");
    // Load coinciding with tick, with and without halt.
    step(1, 1, 1, 0, 5'd0, "R8");
    step(1, 1, 1, 1, 5'd8, "R8");
    step(1, 0, 1, 1, 5'd0, "R6");
    step(1, 0, 0, 0, 5'd0, "R5");
    // Disable with a load pending, then load while disabled.
    step(0, 1, 1, 0, 5'd9, "R9");
    step(0, 1, 0, 0, 5'd1, "R9");
    // Drain the largest entry fully.
    step(1, 1, 0, 0, 5'd1, "R2");
    for (int i = 0; i < 256; i++) step(1, 0, 1, 0, 5'd0, autoTag(1, 0, 1, 0, 5'd0));
    // Random phases.
    for (int i = 0; i < 6000; i++) begin
      bit en = ($urandom % 20) != 0;
      bit ld = ($urandom % 40) == 0;
      bit tk = ($urandom % 2) == 0;
      bit hl = ($urandom % 6) == 0;
      logic [4:0] idx = 5'($urandom);
      step(en, ld, tk, hl, idx, autoTag(en, ld, tk, hl, idx));
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule